// File: doc/BRIEF.md
# Adaptive Drift Scrub Controller

This controller keeps the lines of a multi-level resistive memory from losing data to slow resistance drift. It does not rewrite lines blindly at a fixed rate. It walks through the line addresses one at a time and issues a cheap check read for each line. It then looks at the error count that the external ECC decoder returns, and rewrites (scrubs) the line only when that count has come too close to the code's correction limit. The code corrects `ECC_N` errors and detects `ECC_N+1`. A scrub is requested once the reported count reaches `ECC_N - h`, where `h` is a run-time headroom input. A headroom of zero gives the plain threshold of `ECC_N`.

Checking starts at a slow rate: one check every `START_IVL` cycles. Each read whose error count is above `RATE_LIMIT` halves the check interval, down to a floor of one cycle. Reads that report a hard error bump a saturating per-line counter. When that counter passes `HARD_LIMIT`, the line is retired: it sets a bit in the defunct map and is never read or scrubbed again. A host write refreshes a line's cells, so the next check that falls on that line is dropped without a memory access.

Only one request is outstanding at a time. A request holds its address and kind until the memory side answers with a one-cycle response pulse.

The FSM has four states:
- **WAIT**: the interval timer runs.
- **PICK**: the controller steps over defunct lines, or drops a check on a freshly written line.
- **READ**: a check read is outstanding.
- **SCRUB**: a rewrite is outstanding.

The transitions are:
- WAIT→PICK when the timer expires.
- PICK→PICK on a defunct line.
- PICK→WAIT on a fresh line.
- PICK→READ otherwise.
- READ→SCRUB when the error count reaches the threshold and the line is not being retired.
- READ→WAIT on any other response.
- SCRUB→WAIT on its response.

Top module: `drift_scrub_ctrl`

## Requirements
- R1: After reset, no request is raised, `defunct_map` is all zero and `cur_interval` equals `START_IVL` (16). No request appears during the first `START_IVL` cycles after reset is released.
- R2: Check reads (`mem_req_scrub`=0) visit line addresses in ascending order and wrap from `LINES-1` back to 0.
- R3: While `mem_req_valid` is high and no response has arrived, `mem_req_addr` and `mem_req_scrub` stay stable. A new request starts only after the response to the previous one.
- R4: A read response with `mem_rsp_errs >= ECC_N - cfg_headroom` and no hard error raises a scrub request (`mem_req_scrub`=1) for the same address in the next cycle. A smaller count raises no scrub.
- R5: With `cfg_headroom`=0 the scrub threshold is `ECC_N` (4): a count of 3 raises no scrub and a count of 4 does.
- R6: A read response with `mem_rsp_errs > RATE_LIMIT` (2) halves `cur_interval` in the next cycle, and `cur_interval` never goes below 1.
- R7: Each read response with `mem_rsp_hard`=1 increments a saturating per-line counter. The response that takes the counter above `HARD_LIMIT` (1) sets that line's bit in `defunct_map` (bit i = line i) in the next cycle, and the bit never clears.
- R8: A defunct line is never requested again; the walk passes straight to the next live line.
- R9: A host write (`host_wr_valid`) to a line drops the next scheduled check of that line without a request. The check after that is made normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_headroom | input | ERR_W | Headroom subtracted from ECC_N to form the scrub threshold |
| host_wr_valid | input | 1 | A normal write to a line took place this cycle |
| host_wr_addr | input | AW | Line written by the host |
| mem_req_valid | output | 1 | Request to the memory side is pending |
| mem_req_scrub | output | 1 | 0 = check read, 1 = scrub (read-correct-write) |
| mem_req_addr | output | AW | Line addressed by the request |
| mem_rsp_valid | input | 1 | One-cycle response to the pending request |
| mem_rsp_errs | input | ERR_W | Errors found in the line (valid with a read response) |
| mem_rsp_hard | input | 1 | The read found a hard (stuck) error |
| defunct_map | output | LINES | Bit per retired line |
| cur_interval | output | IVL_W | Current check interval in cycles |

## Verification
Each decision is registered once. A scrub request, a halved `cur_interval` and a new `defunct_map` bit all become visible in the cycle after the edge that takes the response. The bench drives the response at a falling edge, lets one rising edge pass and samples at the next falling edge. The next check read comes an interval plus one or two cycles after a response. Its exact arrival is not predicted: the bench waits for `mem_req_valid` with a bounded timeout and then checks the address and kind against its own model of the walk, the defunct lines and the freshly written lines. The first-request bound of R1 is checked by sampling every cycle of the first `START_IVL` cycles.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_PICK  = 2'd1,
        ST_READ  = 2'd2,
        ST_SCRUB = 2'd3
    } dsc_state_e;
endpackage

// File: rtl/dsc_interval.sv
// Check-interval reload register and down-counting timer.
module dsc_interval #(
    parameter int IVL_W     = 8,
    parameter int START_IVL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             speed_up,
    input  logic             load,
    output logic             expired,
    output logic [IVL_W-1:0] reload_o
);
    localparam logic [IVL_W-1:0] START_V = IVL_W'(START_IVL);
    localparam logic [IVL_W-1:0] ONE_V   = IVL_W'(1);

    logic [IVL_W-1:0] reload_q;
    logic [IVL_W-1:0] timer_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= START_V;
        end else if (speed_up) begin
            reload_q <= (reload_q > ONE_V) ? (reload_q >> 1) : ONE_V;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= START_V;
        end else if (load) begin
            timer_q <= reload_q;
        end else if (timer_q > ONE_V) begin
            timer_q <= timer_q - ONE_V;
        end
    end

    assign expired  = (timer_q <= ONE_V);
    assign reload_o = reload_q;
endmodule

// File: rtl/dsc_lines.sv
// Per-line state: walk pointer, hard-error counters, defunct and fresh bits.
module dsc_lines #(
    parameter int LINES      = 8,
    parameter int AW         = 3,
    parameter int HARD_LIMIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [AW-1:0]    wr_addr,
    input  logic             advance,
    input  logic             clr_fresh,
    input  logic             hard_hit,
    output logic [AW-1:0]    ptr_o,
    output logic             cur_defunct,
    output logic             cur_fresh,
    output logic             cur_at_limit,
    output logic [LINES-1:0] defunct_map
);
    localparam int            HC_W   = $clog2(HARD_LIMIT + 2);
    localparam logic [HC_W-1:0] HC_LIM = HC_W'(HARD_LIMIT);
    localparam logic [HC_W-1:0] HC_MAX = HC_W'(HARD_LIMIT + 1);
    localparam logic [AW-1:0]   LAST   = AW'(LINES - 1);

    logic [AW-1:0]    ptr_q;
    logic [LINES-1:0] fresh_vec;
    logic [LINES-1:0] limit_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + AW'(1);
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [HC_W-1:0] hc_q;
        logic            dead_q;
        logic            fresh_q;
        logic            sel;

        assign sel = (ptr_q == AW'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hc_q    <= '0;
                dead_q  <= 1'b0;
                fresh_q <= 1'b0;
            end else begin
                if (hard_hit && sel) begin
                    if (hc_q != HC_MAX) hc_q <= hc_q + HC_W'(1);
                    if (hc_q >= HC_LIM) dead_q <= 1'b1;
                end
                if (wr_valid && wr_addr == AW'(g)) begin
                    fresh_q <= 1'b1;
                end else if (clr_fresh && sel) begin
                    fresh_q <= 1'b0;
                end
            end
        end

        assign defunct_map[g] = dead_q;
        assign fresh_vec[g]   = fresh_q;
        assign limit_vec[g]   = (hc_q >= HC_LIM);
    end

    assign ptr_o        = ptr_q;
    assign cur_defunct  = defunct_map[ptr_q];
    assign cur_fresh    = fresh_vec[ptr_q];
    assign cur_at_limit = limit_vec[ptr_q];
endmodule

// File: rtl/drift_scrub_ctrl.sv
module drift_scrub_ctrl #(
    parameter int LINES      = 8,
    parameter int ECC_N      = 4,
    parameter int IVL_W      = 8,
    parameter int START_IVL  = 16,
    parameter int RATE_LIMIT = 2,
    parameter int HARD_LIMIT = 1,
    parameter int AW         = $clog2(LINES),
    parameter int ERR_W      = $clog2(ECC_N + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ERR_W-1:0] cfg_headroom,
    input  logic             host_wr_valid,
    input  logic [AW-1:0]    host_wr_addr,
    output logic             mem_req_valid,
    output logic             mem_req_scrub,
    output logic [AW-1:0]    mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ERR_W-1:0] mem_rsp_errs,
    input  logic             mem_rsp_hard,
    output logic [LINES-1:0] defunct_map,
    output logic [IVL_W-1:0] cur_interval
);
    import dsc_pkg::*;

    localparam logic [ERR_W-1:0] N_V    = ERR_W'(ECC_N);
    localparam logic [ERR_W-1:0] RATE_V = ERR_W'(RATE_LIMIT);

    dsc_state_e       state_q, state_d;
    logic             expired, load, speed_up;
    logic             advance, clr_fresh, hard_hit;
    logic             cur_defunct, cur_fresh, cur_at_limit;
    logic [AW-1:0]    ptr;
    logic [ERR_W-1:0] scrub_thr;

    assign scrub_thr = (cfg_headroom >= N_V) ? '0 : (N_V - cfg_headroom);

    dsc_interval #(.IVL_W(IVL_W), .START_IVL(START_IVL)) u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .speed_up (speed_up),
        .load     (load),
        .expired  (expired),
        .reload_o (cur_interval)
    );

    dsc_lines #(.LINES(LINES), .AW(AW), .HARD_LIMIT(HARD_LIMIT)) u_lines (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_valid     (host_wr_valid),
        .wr_addr      (host_wr_addr),
        .advance      (advance),
        .clr_fresh    (clr_fresh),
        .hard_hit     (hard_hit),
        .ptr_o        (ptr),
        .cur_defunct  (cur_defunct),
        .cur_fresh    (cur_fresh),
        .cur_at_limit (cur_at_limit),
        .defunct_map  (defunct_map)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    // Next state and per-transition strobes
    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        speed_up  = 1'b0;
        advance   = 1'b0;
        clr_fresh = 1'b0;
        hard_hit  = 1'b0;
        unique case (state_q)
            ST_WAIT: begin
                if (expired) state_d = ST_PICK;
            end
            ST_PICK: begin
                if (cur_defunct) begin
                    advance = 1'b1;
                end else if (cur_fresh) begin
                    clr_fresh = 1'b1;
                    advance   = 1'b1;
                    load      = 1'b1;
                    state_d   = ST_WAIT;
                end else begin
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_rsp_valid) begin
                    hard_hit = mem_rsp_hard;
                    speed_up = (mem_rsp_errs > RATE_V);
                    if (!(mem_rsp_hard && cur_at_limit) && mem_rsp_errs >= scrub_thr) begin
                        state_d = ST_SCRUB;
                    end else begin
                        advance = 1'b1;
                        load    = 1'b1;
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_SCRUB: begin
                if (mem_rsp_valid) begin
                    advance = 1'b1;
                    load    = 1'b1;
                    state_d = ST_WAIT;
                end
            end
            default: state_d = ST_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req_valid = (state_q == ST_READ) || (state_q == ST_SCRUB);
        mem_req_scrub = (state_q == ST_SCRUB);
        mem_req_addr  = ptr;
    end
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int LINES      = 8,
    parameter int ECC_N      = 4,
    parameter int IVL_W      = 8,
    parameter int RATE_LIMIT = 2,
    parameter int AW         = $clog2(LINES),
    parameter int ERR_W      = $clog2(ECC_N + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ERR_W-1:0] cfg_headroom,
    input logic             mem_req_valid,
    input logic             mem_req_scrub,
    input logic [AW-1:0]    mem_req_addr,
    input logic             mem_rsp_valid,
    input logic [ERR_W-1:0] mem_rsp_errs,
    input logic             mem_rsp_hard,
    input logic [LINES-1:0] defunct_map,
    input logic [IVL_W-1:0] cur_interval
);
    logic [ERR_W-1:0] thr;
    assign thr = (cfg_headroom >= ERR_W'(ECC_N)) ? '0 : (ERR_W'(ECC_N) - cfg_headroom);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_rsp_valid |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_scrub)); // R3

    AST_SCRUB_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_scrub && mem_rsp_valid && !mem_rsp_hard && mem_rsp_errs >= thr
        |=> mem_req_valid && mem_req_scrub && mem_req_addr == $past(mem_req_addr)); // R4

    AST_RATE_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_scrub && mem_rsp_valid && mem_rsp_errs > ERR_W'(RATE_LIMIT)
        |=> cur_interval == (($past(cur_interval) > IVL_W'(1)) ? ($past(cur_interval) >> 1) : IVL_W'(1))); // R6

    AST_IVL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cur_interval != '0); // R6

    AST_DEFUNCT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(defunct_map) & ~defunct_map) == '0); // R7

    AST_NO_REQ_DEFUNCT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> !defunct_map[mem_req_addr]); // R8
endmodule

bind drift_scrub_ctrl dsc_checker #(
    .LINES(LINES), .ECC_N(ECC_N), .IVL_W(IVL_W), .RATE_LIMIT(RATE_LIMIT)
) u_dsc_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_headroom  (cfg_headroom),
    .mem_req_valid (mem_req_valid),
    .mem_req_scrub (mem_req_scrub),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_errs  (mem_rsp_errs),
    .mem_rsp_hard  (mem_rsp_hard),
    .defunct_map   (defunct_map),
    .cur_interval  (cur_interval)
);

// File: tb/test_drift_scrub_ctrl.sv
`timescale 1ns/1ps
module test_drift_scrub_ctrl;
    localparam int LINES = 8;
    localparam int AW    = 3;
    localparam int ERR_W = 3;
    localparam int IVL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ERR_W-1:0] cfg_headroom = '0;
    logic             host_wr_valid = 1'b0;
    logic [AW-1:0]    host_wr_addr = '0;
    logic             mem_req_valid, mem_req_scrub;
    logic [AW-1:0]    mem_req_addr;
    logic             mem_rsp_valid = 1'b0;
    logic [ERR_W-1:0] mem_rsp_errs = '0;
    logic             mem_rsp_hard = 1'b0;
    logic [LINES-1:0] defunct_map;
    logic [IVL_W-1:0] cur_interval;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int ptr_exp = 0;
    logic [LINES-1:0] dead_exp = '0;

    always #2 clk = ~clk;

    drift_scrub_ctrl i_drift_scrub_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_headroom(cfg_headroom),
        .host_wr_valid(host_wr_valid), .host_wr_addr(host_wr_addr),
        .mem_req_valid(mem_req_valid), .mem_req_scrub(mem_req_scrub),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_errs(mem_rsp_errs), .mem_rsp_hard(mem_rsp_hard),
        .defunct_map(defunct_map), .cur_interval(cur_interval)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_live(input int p);
        int n = p;
        for (int k = 0; k < LINES; k++) begin
            n = (n + 1) % LINES;
            if (!dead_exp[n]) return n;
        end
        return n;
    endfunction

    task automatic wait_req(input string req);
        int t = 0;
        while (!mem_req_valid && t < 400) begin
            @(negedge clk);
            t++;
        end
        check(mem_req_valid, req, 0, 1);
    endtask

    task automatic respond(input int errs, input bit hard);
        mem_rsp_valid = 1'b1;
        mem_rsp_errs  = ERR_W'(errs);
        mem_rsp_hard  = hard;
        @(posedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_errs  = '0;
        mem_rsp_hard  = 1'b0;
    endtask

    // One plain read of the expected line, answered with the given values.
    task automatic read_expected(input string req, input int errs, input bit hard);
        wait_req(req);
        check(int'(mem_req_addr) == ptr_exp, req, int'(mem_req_addr), ptr_exp);
        check(mem_req_scrub == 1'b0, req, int'(mem_req_scrub), 0);
        respond(errs, hard);
    endtask

    task automatic t_reset;
        bit seen = 0;
        check(mem_req_valid == 1'b0, "R1", int'(mem_req_valid), 0);
        check(defunct_map == '0, "R1", int'(defunct_map), 0);
        check(cur_interval == IVL_W'(16), "R1", int'(cur_interval), 16);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (mem_req_valid) seen = 1;
        end
        check(!seen, "R1 early request", int'(seen), 0);
    endtask

    task automatic t_order;
        for (int i = 0; i < 9; i++) begin
            wait_req("R2");
            check(int'(mem_req_addr) == ptr_exp, "R2 order", int'(mem_req_addr), ptr_exp);
            check(mem_req_scrub == 1'b0, "R2 kind", int'(mem_req_scrub), 0);
            if (i == 0) begin
                repeat (3) @(negedge clk);
                check(mem_req_valid && int'(mem_req_addr) == ptr_exp && !mem_req_scrub,
                      "R3 held", int'(mem_req_addr), ptr_exp);
            end
            respond(0, 0);
            check(mem_req_valid == 1'b0, "R3 released", int'(mem_req_valid), 0);
            ptr_exp = next_live(ptr_exp);
        end
    endtask

    task automatic t_scrub;
        cfg_headroom = ERR_W'(1);
        read_expected("R4", 2, 0);
        check(mem_req_valid == 1'b0, "R4 below threshold", int'(mem_req_valid), 0);
        check(cur_interval == IVL_W'(16), "R6 no speed-up", int'(cur_interval), 16);
        ptr_exp = next_live(ptr_exp);

        read_expected("R4", 3, 0);
        check(mem_req_valid && mem_req_scrub && int'(mem_req_addr) == ptr_exp,
              "R4 scrub", int'(mem_req_scrub), 1);
        check(cur_interval == IVL_W'(8), "R6 halve", int'(cur_interval), 8);
        respond(0, 0);
        check(mem_req_valid == 1'b0, "R4 scrub done", int'(mem_req_valid), 0);
        ptr_exp = next_live(ptr_exp);

        cfg_headroom = '0;
        read_expected("R5", 3, 0);
        check(mem_req_valid == 1'b0, "R5 count 3", int'(mem_req_valid), 0);
        check(cur_interval == IVL_W'(4), "R6 halve", int'(cur_interval), 4);
        ptr_exp = next_live(ptr_exp);

        read_expected("R5", 4, 0);
        check(mem_req_valid && mem_req_scrub, "R5 count 4", int'(mem_req_scrub), 1);
        check(cur_interval == IVL_W'(2), "R6 halve", int'(cur_interval), 2);
        respond(0, 0);
        ptr_exp = next_live(ptr_exp);

        read_expected("R6", 3, 0);
        check(cur_interval == IVL_W'(1), "R6 halve", int'(cur_interval), 1);
        ptr_exp = next_live(ptr_exp);
        read_expected("R6", 3, 0);
        check(cur_interval == IVL_W'(1), "R6 floor", int'(cur_interval), 1);
        ptr_exp = next_live(ptr_exp);
    endtask

    task automatic t_defunct;
        int victim = ptr_exp;
        read_expected("R7", 0, 1);
        check(defunct_map == '0, "R7 first hard", int'(defunct_map), 0);
        ptr_exp = next_live(ptr_exp);
        while (ptr_exp != victim) begin
            read_expected("R7", 0, 0);
            ptr_exp = next_live(ptr_exp);
        end
        read_expected("R7", 4, 1);
        check(defunct_map == LINES'(1 << victim), "R7 retire", int'(defunct_map), 1 << victim);
        check(mem_req_valid == 1'b0, "R7 no scrub on retire", int'(mem_req_valid), 0);
        dead_exp[victim] = 1'b1;
        ptr_exp = next_live(ptr_exp);
        for (int i = 0; i < LINES; i++) begin
            wait_req("R8");
            check(int'(mem_req_addr) != victim, "R8 skip", int'(mem_req_addr), ptr_exp);
            check(int'(mem_req_addr) == ptr_exp, "R8 order", int'(mem_req_addr), ptr_exp);
            respond(0, 0);
            ptr_exp = next_live(ptr_exp);
        end
        check(defunct_map == LINES'(1 << victim), "R7 sticky", int'(defunct_map), 1 << victim);
    endtask

    task automatic t_fresh;
        int target;
        wait_req("R9");
        check(int'(mem_req_addr) == ptr_exp, "R9 order", int'(mem_req_addr), ptr_exp);
        target = next_live(ptr_exp);
        host_wr_valid = 1'b1;
        host_wr_addr  = AW'(target);
        @(negedge clk);
        host_wr_valid = 1'b0;
        respond(0, 0);
        ptr_exp = next_live(target);
        wait_req("R9");
        check(int'(mem_req_addr) == ptr_exp, "R9 dropped check", int'(mem_req_addr), ptr_exp);
        respond(0, 0);
        ptr_exp = next_live(ptr_exp);
        while (ptr_exp != target) begin
            read_expected("R9", 0, 0);
            ptr_exp = next_live(ptr_exp);
        end
        wait_req("R9");
        check(int'(mem_req_addr) == target, "R9 later check", int'(mem_req_addr), target);
        respond(0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_scrub();
        t_defunct();
        t_fresh();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule